// File: doc/BRIEF.md
# Thermal Range and Backup Blower Controller

This block sorts a stream of module temperature readings, in whole degrees Celsius, into clock-degrade ranges. It also picks the speed of a backup air blower and watches for a refrigeration loop that must be shut off. Each reading arrives on a valid/ready stream together with the module's power state. The block raises an over-temperature flag and reports one of three ranges: normal, first degrade or second degrade. A one-cycle interrupt marks every change of the reported range, so a clock-steering agent knows when to act. The block also commands the blower (off, low or high) and drops a loop-enable output when the module has drawn low power for too long.

Every threshold has a hysteresis gap, so a reading that wobbles near a limit does not make the range or the blower oscillate. The block is fail-safe. If the link that carries the readings is reported invalid, the block reports a degraded range whatever the last temperature was. It then holds a cooler-defect flag, and the normal range is reported again only after a repair-complete pulse.

The stream never applies back-pressure: `smp_ready` is held high, and every cycle with `smp_valid` high delivers exactly one sample. A sample's temperature and power state take effect at the clock edge that accepts it. The sample stream also serves as the tick for the low-power timer. Cycles without `smp_valid` leave all temperature-derived state unchanged.

Top module: `thermal_guard`

## Requirements
- R1: `smp_ready` is always 1. Temperature and power state are taken only at edges where `smp_valid` is 1. Stimulus on `smp_temp` or `pwr_high` with `smp_valid` at 0 changes no output.
- R2: `over_temp` is set by a sample above 34 and cleared by a sample of 34 or below. It updates at the accepting edge.
- R3: The first degrade range is entered on a sample above 35 and left on a sample below 32. `range_code` encodes 00 as normal, 01 as first degrade and 10 as second degrade. `range_code` follows an accepted sample one clock after the accepting edge.
- R4: The second degrade range is entered on a sample above `cfg_r2_enter` and left on a sample below `cfg_r2_enter` minus 3. On leaving it, the range becomes first degrade unless the sample is also below 32.
- R5: `range_irq` is high for exactly the one cycle in which `range_code` takes a new value.
- R6: The blower is switched on by a sample above 38 and off by a sample below 35. `blower_cmd` encodes 00 as off, 01 as low and 10 as high. 11 is never driven.
- R7: Whenever the temperature-derived range is second degrade, `blower_cmd` is high. Otherwise, while the blower is on, `blower_cmd` is high when the last sample's `pwr_high` was 1 and low when it was 0.
- R8: After `cfg_lp_ticks` consecutive samples with `pwr_high` at 0 (a setting of 0 acts as 1), `loop_enable` drops to 0 and `blower_cmd` is at least low. The next sample with `pwr_high` at 1 restores `loop_enable` to 1 and ends this condition.
- R9: While `comm_ok` is 0, `range_code` is not normal from the next cycle on, whatever the temperature.
- R10: `cooler_bad` is set when the temperature-derived range leaves normal or when `comm_ok` is 0. While it is set, `range_code` stays at first degrade or above, even after the temperature recovers.
- R11: A `repair_done` pulse clears `cooler_bad` only if `comm_ok` is 1 and the temperature-derived range is normal. In any other case the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Temperature sample valid |
| smp_ready | output | 1 | Sample accepted (always 1) |
| smp_temp | input | TEMP_W | Rationalized module temperature, degrees C, unsigned |
| pwr_high | input | 1 | Module power state with the sample: 1 = high, 0 = low |
| comm_ok | input | 1 | Reading path valid; 0 forces a degraded report |
| repair_done | input | 1 | Repair-complete pulse |
| cfg_r2_enter | input | TEMP_W | Second-degrade entry threshold (exit is 3 below) |
| cfg_lp_ticks | input | LP_W | Consecutive low-power samples before loop shut-off |
| over_temp | output | 1 | Over-temperature error |
| range_code | output | 2 | Reported degrade range |
| range_irq | output | 1 | One-cycle pulse on range change |
| blower_cmd | output | 2 | Backup blower command |
| cooler_bad | output | 1 | Latched defective-cooler flag |
| loop_enable | output | 1 | Refrigeration loop enable |

## Verification
The hardest state to reach is one where the reported range and the temperature-derived range disagree. This is the latched first-degrade report that `cooler_bad` holds after the temperature has fallen back below 32, or after a link loss with a cool module. To get there, the bench first raises the temperature into a degrade range, or drops `comm_ok` while the module is cool. It then sends cool samples and confirms that the report stays degraded. It also sends `repair_done` pulses while the link is down and while the module is still hot, and checks that they are ignored. Only after that does the bench issue a valid repair and count the interrupt pulses across the whole episode.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  typedef enum logic [1:0] {
    RNG_NORM = 2'b00,
    RNG_DEG1 = 2'b01,
    RNG_DEG2 = 2'b10
  } rng_e;

  typedef enum logic [1:0] {
    BLW_OFF  = 2'b00,
    BLW_LOW  = 2'b01,
    BLW_HIGH = 2'b10
  } blw_e;
endpackage

// File: rtl/tg_hyst.sv
// Two-threshold comparator: a sample above hi sets the level, a sample below lo clears it.
module tg_hyst #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] val,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lvl <= 1'b0;
    else if (en) begin
      if (val > hi)      lvl <= 1'b1;
      else if (val < lo) lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/tg_lowpwr.sv
// Counts consecutive low-power samples; flags an extended low-power condition.
module tg_lowpwr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pwr_high,
  input  logic [CW-1:0] limit,
  output logic          lp_ext
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] lim_eff;

  assign cnt_inc = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
  assign lim_eff = (limit == '0) ? CW'(1) : limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lp_ext <= 1'b0;
    end else if (en) begin
      if (pwr_high) begin
        cnt_q  <= '0;
        lp_ext <= 1'b0;
      end else begin
        cnt_q  <= cnt_inc;
        lp_ext <= (cnt_inc >= lim_eff);
      end
    end
  end
endmodule

// File: rtl/tg_range_latch.sv
// Fail-safe range reporting with a sticky cooler-defect flag and change interrupt.
module tg_range_latch
  import thermal_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rng_e       thr_rng,
  input  logic       comm_ok,
  input  logic       repair_done,
  output logic [1:0] range_code,
  output logic       range_irq,
  output logic       cooler_bad
);
  logic bad_next;
  rng_e floor_rng;
  rng_e rpt_next;
  rng_e rpt_q;

  always_comb begin
    if (!comm_ok || thr_rng != RNG_NORM) bad_next = 1'b1;
    else if (repair_done)                bad_next = 1'b0;
    else                                 bad_next = cooler_bad;
    floor_rng = (cooler_bad || !comm_ok) ? RNG_DEG1 : RNG_NORM;
    rpt_next  = (thr_rng > floor_rng) ? thr_rng : floor_rng;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cooler_bad <= 1'b0;
      rpt_q      <= RNG_NORM;
      range_irq  <= 1'b0;
    end else begin
      cooler_bad <= bad_next;
      rpt_q      <= rpt_next;
      range_irq  <= (rpt_next != rpt_q);
    end
  end

  assign range_code = rpt_q;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int LP_W       = 8,
  parameter int OVR_LIM    = 34,
  parameter int DEG1_ENTER = 35,
  parameter int DEG1_EXIT  = 32,
  parameter int FAN_ENTER  = 38,
  parameter int FAN_EXIT   = 35,
  parameter int DEG2_HYST  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic              pwr_high,
  input  logic              comm_ok,
  input  logic              repair_done,
  input  logic [TEMP_W-1:0] cfg_r2_enter,
  input  logic [LP_W-1:0]   cfg_lp_ticks,
  output logic              over_temp,
  output logic [1:0]        range_code,
  output logic              range_irq,
  output logic [1:0]        blower_cmd,
  output logic              cooler_bad,
  output logic              loop_enable
);
  localparam logic [TEMP_W-1:0] OVR_HI  = TEMP_W'(OVR_LIM);
  localparam logic [TEMP_W-1:0] OVR_LO  = TEMP_W'(OVR_LIM + 1);
  localparam logic [TEMP_W-1:0] D1_HI   = TEMP_W'(DEG1_ENTER);
  localparam logic [TEMP_W-1:0] D1_LO   = TEMP_W'(DEG1_EXIT);
  localparam logic [TEMP_W-1:0] FAN_HI  = TEMP_W'(FAN_ENTER);
  localparam logic [TEMP_W-1:0] FAN_LO  = TEMP_W'(FAN_EXIT);
  localparam logic [TEMP_W-1:0] D2_GAP  = TEMP_W'(DEG2_HYST);

  logic              take;
  logic [TEMP_W-1:0] d2_lo;
  logic              deg1_lvl, deg2_lvl, fan_lvl;
  logic              pwr_q;
  logic              lp_ext;
  rng_e              thr_rng;
  blw_e              blw;

  assign smp_ready = 1'b1;
  assign take      = smp_valid & smp_ready;
  assign d2_lo     = (cfg_r2_enter > D2_GAP) ? cfg_r2_enter - D2_GAP : '0;

  tg_hyst #(.W(TEMP_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .en(take), .val(smp_temp),
    .hi(OVR_HI), .lo(OVR_LO), .lvl(over_temp)
  );
  tg_hyst #(.W(TEMP_W)) u_deg1 (
    .clk(clk), .rst_n(rst_n), .en(take), .val(smp_temp),
    .hi(D1_HI), .lo(D1_LO), .lvl(deg1_lvl)
  );
  tg_hyst #(.W(TEMP_W)) u_deg2 (
    .clk(clk), .rst_n(rst_n), .en(take), .val(smp_temp),
    .hi(cfg_r2_enter), .lo(d2_lo), .lvl(deg2_lvl)
  );
  tg_hyst #(.W(TEMP_W)) u_fan (
    .clk(clk), .rst_n(rst_n), .en(take), .val(smp_temp),
    .hi(FAN_HI), .lo(FAN_LO), .lvl(fan_lvl)
  );

  tg_lowpwr #(.CW(LP_W)) u_lp (
    .clk(clk), .rst_n(rst_n), .en(take), .pwr_high(pwr_high),
    .limit(cfg_lp_ticks), .lp_ext(lp_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pwr_q <= 1'b1;
    else if (take) pwr_q <= pwr_high;
  end

  always_comb begin
    if (deg2_lvl)      thr_rng = RNG_DEG2;
    else if (deg1_lvl) thr_rng = RNG_DEG1;
    else               thr_rng = RNG_NORM;
  end

  always_comb begin
    if (thr_rng == RNG_DEG2) blw = BLW_HIGH;
    else if (fan_lvl)        blw = pwr_q ? BLW_HIGH : BLW_LOW;
    else if (lp_ext)         blw = BLW_LOW;
    else                     blw = BLW_OFF;
  end

  assign blower_cmd  = blw;
  assign loop_enable = ~lp_ext;

  tg_range_latch u_rng (
    .clk(clk), .rst_n(rst_n), .thr_rng(thr_rng), .comm_ok(comm_ok),
    .repair_done(repair_done), .range_code(range_code),
    .range_irq(range_irq), .cooler_bad(cooler_bad)
  );
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       comm_ok,
  input logic       repair_done,
  input logic [1:0] range_code,
  input logic       range_irq,
  input logic [1:0] blower_cmd,
  input logic       cooler_bad,
  input logic       loop_enable
);
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (range_code != $past(range_code)) |-> range_irq); // R5

  AST_COMM_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !comm_ok |=> (range_code != 2'b00)); // R9

  AST_NORMAL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (range_code == 2'b00) |-> !cooler_bad); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cooler_bad && !repair_done) |=> cooler_bad); // R11

  AST_LOOP_OFF_BLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_enable |-> (blower_cmd != 2'b00)); // R8

  AST_BLOWER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    blower_cmd != 2'b11); // R6
endmodule

bind thermal_guard thermal_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .comm_ok(comm_ok), .repair_done(repair_done),
  .range_code(range_code), .range_irq(range_irq), .blower_cmd(blower_cmd),
  .cooler_bad(cooler_bad), .loop_enable(loop_enable)
);

// File: tb/thermal_guard_tb.sv
`timescale 1ns/1ps
module thermal_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_temp = 8'd25;
  logic       pwr_high = 1'b1;
  logic       comm_ok = 1'b1;
  logic       repair_done = 1'b0;
  logic [7:0] cfg_r2_enter = 8'd45;
  logic [7:0] cfg_lp_ticks = 8'd4;
  logic       over_temp;
  logic [1:0] range_code;
  logic       range_irq;
  logic [1:0] blower_cmd;
  logic       cooler_bad;
  logic       loop_enable;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;

  always #10 clk = ~clk;

  thermal_guard u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_temp(smp_temp), .pwr_high(pwr_high), .comm_ok(comm_ok),
    .repair_done(repair_done), .cfg_r2_enter(cfg_r2_enter),
    .cfg_lp_ticks(cfg_lp_ticks), .over_temp(over_temp),
    .range_code(range_code), .range_irq(range_irq), .blower_cmd(blower_cmd),
    .cooler_bad(cooler_bad), .loop_enable(loop_enable)
  );

  always @(negedge clk) if (rst_n && range_irq) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int t, input logic p);
    @(negedge clk);
    smp_valid = 1'b1; smp_temp = 8'(t); pwr_high = p;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic repair();
    @(negedge clk); repair_done = 1'b1;
    @(negedge clk); repair_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    comm_ok = 1'b1;
    send(25, 1'b1);
    repair();
  endtask

  task automatic t_reset();
    check("R1 ready", smp_ready, 1);
    check("R2 reset over_temp", over_temp, 0);
    check("R3 reset range", range_code, 0);
    check("R6 reset blower", blower_cmd, 0);
    check("R10 reset cooler_bad", cooler_bad, 0);
    check("R8 reset loop_enable", loop_enable, 1);
  endtask

  task automatic t_overtemp();
    send(34, 1'b1);
    check("R2 at 34", over_temp, 0);
    send(35, 1'b1);
    check("R2 at 35", over_temp, 1);
    check("R3 35 stays normal", range_code, 0);
    send(34, 1'b1);
    check("R2 clear at 34", over_temp, 0);
    // R1: unaccepted hot values
    @(negedge clk); smp_temp = 8'd60; pwr_high = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ignored over_temp", over_temp, 0);
    check("R1 ignored range", range_code, 0);
    check("R1 ignored blower", blower_cmd, 0);
    pwr_high = 1'b1;
  endtask

  task automatic t_deg1();
    int i0;
    i0 = irq_cnt;
    send(36, 1'b1);
    check("R3 enter deg1", range_code, 1);
    check("R5 irq on entry", irq_cnt - i0, 1);
    check("R10 flag set", cooler_bad, 1);
    check("R6 blower off at 36", blower_cmd, 0);
    send(38, 1'b1);
    check("R6 blower off at 38", blower_cmd, 0);
    send(39, 1'b1);
    check("R7 blower high pwr high", blower_cmd, 2);
    send(35, 1'b1);
    check("R6 blower held at 35", blower_cmd, 2);
    send(34, 1'b1);
    check("R6 blower off below 35", blower_cmd, 0);
    send(32, 1'b1);
    check("R3 held at 32", range_code, 1);
    send(31, 1'b1);
    check("R10 held after cool", range_code, 1);
    check("R10 flag held", cooler_bad, 1);
    check("R5 no extra irq", irq_cnt - i0, 1);
    repair();
    check("R11 repair clears", cooler_bad, 0);
    check("R11 range normal", range_code, 0);
    check("R5 irq on return", irq_cnt - i0, 2);
    check("R5 irq is one cycle", range_irq, 0);
  endtask

  task automatic t_lowpwr_blower();
    send(39, 1'b0);
    check("R7 blower low pwr low", blower_cmd, 1);
    settle();
  endtask

  task automatic t_deg2();
    send(46, 1'b0);
    check("R4 enter deg2", range_code, 2);
    check("R7 deg2 high regardless", blower_cmd, 2);
    send(43, 1'b0);
    check("R4 held at 43", range_code, 2);
    send(41, 1'b0);
    check("R4 exit to deg1", range_code, 1);
    check("R7 deg1 low pwr", blower_cmd, 1);
    settle();
    cfg_r2_enter = 8'd40;
    send(41, 1'b1);
    check("R4 prog enter", range_code, 2);
    send(37, 1'b1);
    check("R4 prog held at 37", range_code, 2);
    send(36, 1'b1);
    check("R4 prog exit", range_code, 1);
    cfg_r2_enter = 8'd45;
    settle();
    check("R11 clean after deg2", range_code, 0);
  endtask

  task automatic t_extlow();
    send(30, 1'b0); send(30, 1'b0); send(30, 1'b0);
    check("R8 before limit loop", loop_enable, 1);
    check("R8 before limit blower", blower_cmd, 0);
    send(30, 1'b0);
    check("R8 at limit loop", loop_enable, 0);
    check("R8 at limit blower", blower_cmd, 1);
    send(30, 1'b1);
    check("R8 restore loop", loop_enable, 1);
    check("R8 restore blower", blower_cmd, 0);
  endtask

  task automatic t_comm();
    int i0;
    i0 = irq_cnt;
    @(negedge clk); comm_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 degrade on comm loss", range_code, 1);
    check("R9 flag set", cooler_bad, 1);
    repair();
    check("R11 repair ignored comm down", cooler_bad, 1);
    @(negedge clk); comm_ok = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 held after comm back", range_code, 1);
    repair();
    check("R11 repair after comm", range_code, 0);
    check("R5 irq count comm", irq_cnt - i0, 2);
  endtask

  task automatic t_hot_repair();
    send(36, 1'b1);
    repair();
    check("R11 repair ignored hot", cooler_bad, 1);
    check("R11 range kept hot", range_code, 1);
    settle();
    check("R11 final clean", range_code, 0);
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_overtemp();
    t_deg1();
    t_lowpwr_blower();
    t_deg2();
    t_extlow();
    t_comm();
    t_hot_repair();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule